// File: doc/BRIEF.md
# Serial Magnitude Comparator, Least Significant Bit First

This block compares two unsigned binary numbers that arrive one bit per clock on two serial lines, lowest-order bit first. After every rising edge its output reports whether the number built from all x bits taken since the last start is strictly greater than the number built from the y bits taken over the same edges. There is no word length: a comparison runs for as many cycles as the source keeps sending pairs, and the output is valid after every edge.

Each new bit pair outranks every pair taken before it. So a pair whose bits differ settles the verdict on its own, and a pair whose bits match leaves the previous verdict in place. A single flip-flop therefore holds the whole state. A synchronous start input clears the verdict, so that a new comparison begins from "not greater".

Top module: `serial_gt_cmp`

## Requirements
- R1: On a rising edge with `start` = 1, `x_gt_y` becomes 0 whatever `x_bit` and `y_bit` are, and that edge's pair is not taken into the comparison.
- R2: On a rising edge with `start` = 0, `x_bit` = 1 and `y_bit` = 0, `x_gt_y` becomes 1.
- R3: On a rising edge with `start` = 0, `x_bit` = 0 and `y_bit` = 1, `x_gt_y` becomes 0.
- R4: On a rising edge with `start` = 0 and `x_bit` equal to `y_bit`, `x_gt_y` keeps its previous value.
- R5: After each edge, `x_gt_y` is 1 exactly when X > Y. Here X and Y are the unsigned numbers whose bit k is the `x_bit` or `y_bit` taken on the k-th edge without start since the last start, counting from bit 0.
- R6: `x_gt_y` changes only at rising edges of `clk`. A change of the inputs between edges leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; inputs are taken on its rising edge |
| start | input | 1 | Synchronous start: clears the verdict and begins a new comparison |
| x_bit | input | 1 | Next bit of X, lowest-order bit first |
| y_bit | input | 1 | Next bit of Y, lowest-order bit first |
| x_gt_y | output | 1 | 1 when X taken so far is strictly greater than Y taken so far |

## Verification
The bound checker tests, on every cycle, the single-edge rules: start clears the verdict, a differing pair sets or clears it, and a matching pair holds it. Only the bench's scenarios can show that chaining those rules gives the correct magnitude verdict over whole sequences (R5). The bench builds X and Y as integers and compares them after each edge, over the worked example, fixed patterns and random runs of up to 32 bits. It also shows that a restart in the middle of a comparison drops the old history, and that the output stays still when the inputs move between edges.

// File: rtl/serial_gt_cmp.sv
module serial_gt_cmp (
  input  logic clk,
  input  logic start,
  input  logic x_bit,
  input  logic y_bit,
  output logic x_gt_y
);

  logic gt_q;
  logic gt_d;

  // a differing pair overrides all lower-order history
  assign gt_d = start           ? 1'b0  :
                (x_bit ^ y_bit) ? x_bit : gt_q;

  always_ff @(posedge clk) gt_q <= gt_d;

  assign x_gt_y = gt_q;

endmodule

// File: rtl/serial_gt_cmp_chk.sv
module serial_gt_cmp_chk (
  input logic clk,
  input logic start,
  input logic x_bit,
  input logic y_bit,
  input logic x_gt_y
);

  logic armed = 1'b0;
  always_ff @(posedge clk) if (start) armed <= 1'b1;

  p_start_clears_r1: assert property (@(posedge clk) disable iff (!armed)
    start |=> !x_gt_y);

  p_x_wins_r2: assert property (@(posedge clk) disable iff (!armed)
    (!start && x_bit && !y_bit) |=> x_gt_y);

  p_y_wins_r3: assert property (@(posedge clk) disable iff (!armed)
    (!start && !x_bit && y_bit) |=> !x_gt_y);

  p_equal_holds_r4: assert property (@(posedge clk) disable iff (!armed)
    (!start && (x_bit == y_bit)) |=> $stable(x_gt_y));

endmodule

bind serial_gt_cmp serial_gt_cmp_chk u_chk (
  .clk(clk), .start(start), .x_bit(x_bit), .y_bit(y_bit), .x_gt_y(x_gt_y)
);

// File: tb/sim_serial_gt_cmp.sv
`timescale 1ns/1ps
module sim_serial_gt_cmp;

  logic clk = 1'b0;
  logic start = 1'b0;
  logic x_bit = 1'b0;
  logic y_bit = 1'b0;
  logic x_gt_y;

  int checks = 0;
  int fails = 0;
  logic [63:0] xs, ys;
  int pos;

  always #10 clk = ~clk;

  serial_gt_cmp u0 (.clk(clk), .start(start), .x_bit(x_bit), .y_bit(y_bit), .x_gt_y(x_gt_y));

  task automatic check(input logic exp, input string req);
    checks++;
    if (x_gt_y !== exp) begin
      fails++;
      $display("FAIL %s: x_gt_y=%b expected %b at %0t", req, x_gt_y, exp, $time);
    end
  endtask

  // drive at the falling edge, let one rising edge pass, return at the next falling edge
  task automatic step(input logic s, input logic xv, input logic yv);
    start = s; x_bit = xv; y_bit = yv;
    @(posedge clk);
    @(negedge clk);
    if (s) begin xs = 0; ys = 0; pos = 0; end
    else begin xs[pos] = xv; ys[pos] = yv; pos++; end
  endtask

  task automatic t_reset;
    step(1'b1, 1'b1, 1'b0);
    check(1'b0, "R1 start with x=1,y=0");
    step(1'b0, 1'b1, 1'b0);
    step(1'b1, 1'b1, 1'b0);
    check(1'b0, "R1 start clears a set verdict");
  endtask

  task automatic t_example;
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    check(1'b0, "R4 first pair 0,0 gives 0");
    step(1'b0, 1'b1, 1'b0);
    check(1'b1, "R2 pair 1,0 sets verdict");
  endtask

  task automatic t_pairs;
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    check(1'b1, "R2 x wins");
    step(1'b0, 1'b1, 1'b1);
    check(1'b1, "R4 1,1 holds 1");
    step(1'b0, 1'b0, 1'b0);
    check(1'b1, "R4 0,0 holds 1");
    step(1'b0, 1'b0, 1'b1);
    check(1'b0, "R3 y wins");
    step(1'b0, 1'b1, 1'b1);
    check(1'b0, "R4 1,1 holds 0");
    step(1'b0, 1'b1, 1'b0);
    check(1'b1, "R2 higher x bit overrides");
  endtask

  task automatic t_stable;
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    x_bit = 1'b0; y_bit = 1'b1; start = 1'b1;
    #5;
    check(1'b1, "R6 no change between edges");
    start = 1'b0; x_bit = 1'b1; y_bit = 1'b1;
    #3;
    check(1'b1, "R6 no change between edges");
  endtask

  task automatic t_restart;
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b0);
    step(1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    step(1'b0, 1'b1, 1'b1);
    check(1'b0, "R1 old history dropped after restart");
  endtask

  task automatic t_random(input int runs);
    for (int r = 0; r < runs; r++) begin
      int len = 1 + ($urandom % 32);
      int mode = $urandom % 3;
      step(1'b1, 1'b0, 1'b0);
      for (int k = 0; k < len; k++) begin
        logic xv = 1'($urandom);
        logic yv = (mode == 0) ? xv : 1'($urandom);
        step(1'b0, xv, yv);
        check(logic'(xs > ys), "R5 running magnitude");
      end
    end
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    xs = 0; ys = 0; pos = 0;
    @(negedge clk);
    t_reset();
    t_example();
    t_pairs();
    t_stable();
    t_restart();
    t_random(300);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule